// File: doc/BRIEF.md
# Randomized Line Rotation Wear Leveler

This block spreads line-granular writes evenly over the line slots of each page in a nonvolatile store. Every page owns a small rotate field. When a page frame is handed a new occupant, the block draws a fresh rotate amount from a free-running pseudo-random source and keeps it in that page's field. The amount stays fixed until the frame is allocated again.

Traffic to the store passes through a translation path. A write request names a page and a logical line, and the block returns the physical slot at which that line sits, shifted by the page's rotation. A read request names a physical slot, and the block returns the logical line it holds. Translation is purely combinational from the stored field, so a request and its response form one cycle of a valid/ready stream. Back-pressure is passed straight through: `req_ready` follows `resp_ready`. The response is valid whenever the request is. A request stalled by a low `resp_ready` must be held unchanged by the sender, and the response then stays unchanged as well. The data arrays themselves lie outside the block.

Top module: `wl_rotator`

## Requirements
- R1: After reset every page's rotate field is 0, so any request on any page returns its own line number (identity mapping).
- R2: For a write request (`req_write`=1) on a page with rotate r, `resp_line` = (`req_line` + r) mod 16; for example r=1 sends line 15 to slot 0.
- R3: For a read request (`req_write`=0) on a page with rotate r, `resp_line` = (`req_line` − r) mod 16, undoing the write mapping.
- R4: The random source is a 16-bit maximal-length shift register that loads 0xACE1 in reset and then each clock shifts left, taking as its new bit 0 the XOR of bits 15, 13, 12 and 10. An allocation stores the register's bits [3:0] as they stand in the cycle `alloc_valid` is high.
- R5: A page's rotate field changes only when that page is allocated; allocations of other pages and any number of requests leave it unchanged.
- R6: A request on the same page in the same cycle as that page's allocation is translated with the previous rotate value; the new value applies from the next cycle.
- R7: `resp_valid` equals `req_valid` and `req_ready` equals `resp_ready` in the same cycle; while `resp_ready` is low and the request is held, `resp_valid` stays high and `resp_line` stays unchanged.
- R8: The random source advances every clock whether or not an allocation occurs, so allocations in two consecutive cycles receive two successive register states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Allocate strobe: draw a new rotate for `alloc_page` |
| alloc_page | input | 6 | Page frame being allocated |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_page | input | 6 | Page of the request |
| req_line | input | 4 | Logical line (write) or physical slot (read) |
| req_write | input | 1 | 1 = write mapping, 0 = read realignment |
| resp_valid | output | 1 | Translated index present |
| resp_ready | input | 1 | Consumer accepts the response |
| resp_line | output | 4 | Translated line index |

## Verification
Requests are tried straight after reset on untouched pages, which separates a correct identity state from a stale or random table. Every line of a freshly allocated page is then swept in both directions, so the wrap of the modulo at slot 15 and 0 shows up and a write path built as subtraction is told apart from one built as addition. Back-to-back allocations of two pages, a reallocation of the same page, and an allocation coinciding with a request on that page separate a source that steps every clock from one that steps per allocation, and expose a write-through table. A stalled response under low `resp_ready` shows whether the ready path is passed through and the output held.

// File: rtl/wl_pkg.sv
package wl_pkg;
  localparam int unsigned RND_W    = 16;
  localparam logic [15:0] RND_SEED = 16'hACE1;

  typedef enum logic {
    DIR_READ  = 1'b0,
    DIR_WRITE = 1'b1
  } dir_e;
endpackage

// File: rtl/wl_lfsr.sv
module wl_lfsr
  import wl_pkg::*;
#(
  parameter int unsigned OUT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [OUT_W-1:0] rnd
);
  logic [RND_W-1:0] state_q;
  logic             fb;

  assign fb  = state_q[15] ^ state_q[13] ^ state_q[12] ^ state_q[10];
  assign rnd = state_q[OUT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= RND_SEED;
    else        state_q <= {state_q[RND_W-2:0], fb};
  end

  // R4: a maximal-length register never falls into the all-zero lock state
  p_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);
  // R8: the register moves on every clock
  p_advance_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> state_q != $past(state_q));
endmodule

// File: rtl/wl_shift_table.sv
module wl_shift_table #(
  parameter int unsigned PAGES = 64,
  parameter int unsigned ROT_W = 4,
  localparam int unsigned PW   = $clog2(PAGES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_valid,
  input  logic [PW-1:0]    alloc_page,
  input  logic [ROT_W-1:0] new_rot,
  input  logic [PW-1:0]    rd_page,
  output logic [ROT_W-1:0] rd_rot
);
  logic [ROT_W-1:0] rot_q [PAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < PAGES; p++) rot_q[p] <= '0;
    end else if (alloc_valid) begin
      rot_q[alloc_page] <= new_rot;
    end
  end

  // Read sees the stored value only: a same-cycle allocation applies next cycle (R6)
  assign rd_rot = rot_q[rd_page];

  // R4: an allocation captures the random bits offered in its cycle
  p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid |=> rot_q[$past(alloc_page)] == $past(new_rot));
  // R5: without an allocation, a page read twice gives the same rotate
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !alloc_valid |=> (rd_page != $past(rd_page)) || (rd_rot == $past(rd_rot)));
endmodule

// File: rtl/wl_line_map.sv
module wl_line_map
  import wl_pkg::*;
#(
  parameter int unsigned LINE_W = 4
) (
  input  logic [LINE_W-1:0] rot,
  input  logic [LINE_W-1:0] line_in,
  input  dir_e              dir,
  output logic [LINE_W-1:0] line_out
);
  logic [LINE_W-1:0] fwd, back;

  // Power-of-two line count: modulo comes from truncation
  assign fwd  = line_in + rot;
  assign back = line_in - rot;
  assign line_out = (dir == DIR_WRITE) ? fwd : back;

  // R3: the read path inverts the write path for every input
  always_comb begin
    p_inverse_r3: assert (LINE_W'(fwd - rot) == line_in && LINE_W'(back + rot) == line_in);
  end
endmodule

// File: rtl/wl_rotator.sv
module wl_rotator
  import wl_pkg::*;
#(
  parameter int unsigned PAGES = 64,
  parameter int unsigned LINES = 16,
  localparam int unsigned PW   = $clog2(PAGES),
  localparam int unsigned LW   = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_valid,
  input  logic [PW-1:0] alloc_page,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [PW-1:0] req_page,
  input  logic [LW-1:0] req_line,
  input  logic          req_write,
  output logic          resp_valid,
  input  logic          resp_ready,
  output logic [LW-1:0] resp_line
);
  logic [LW-1:0] fresh_rot;
  logic [LW-1:0] page_rot;
  dir_e          dir;

  assign dir = req_write ? DIR_WRITE : DIR_READ;

  wl_lfsr #(.OUT_W(LW)) u_rnd (
    .clk(clk), .rst_n(rst_n), .rnd(fresh_rot)
  );

  wl_shift_table #(.PAGES(PAGES), .ROT_W(LW)) u_tab (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_page(alloc_page), .new_rot(fresh_rot),
    .rd_page(req_page), .rd_rot(page_rot)
  );

  wl_line_map #(.LINE_W(LW)) u_map (
    .rot(page_rot), .line_in(req_line), .dir(dir), .line_out(resp_line)
  );

  assign resp_valid = req_valid;
  assign req_ready  = resp_ready;

  // R7: a stalled response stays offered and unchanged while the sender holds
  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready && !alloc_valid) |=>
      resp_valid && (!$stable(req_page) || !$stable(req_line) || !$stable(req_write)
                     || $stable(resp_line)));
endmodule

// File: tb/wl_rotator_tb_top.sv
module wl_rotator_tb_top;
  localparam int PAGES = 64;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       alloc_valid = 0;
  logic [5:0] alloc_page = 0;
  logic       req_valid = 0;
  logic       req_ready;
  logic [5:0] req_page = 0;
  logic [3:0] req_line = 0;
  logic       req_write = 0;
  logic       resp_valid;
  logic       resp_ready = 1;
  logic [3:0] resp_line;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  wl_rotator dut_i (.*);

  // Reference random source built from the R4 rule
  logic [15:0] m_rnd;
  always @(posedge clk) begin
    if (!rst_n) m_rnd <= 16'hACE1;
    else        m_rnd <= {m_rnd[14:0], m_rnd[15] ^ m_rnd[13] ^ m_rnd[12] ^ m_rnd[10]};
  end

  logic [3:0] exp_rot [PAGES];
  int    q_exp [$];
  string q_tag [$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: mid-cycle, pop an expectation for every accepted transfer
  always @(negedge clk) begin
    if (rst_n && resp_valid && resp_ready) begin
      if (q_exp.size() == 0) check(0, "R7 unexpected response", resp_line, -1);
      else begin
        int e; string t;
        e = q_exp.pop_front(); t = q_tag.pop_front();
        check(resp_line == 4'(e), t, resp_line, e);
      end
    end
  end

  function automatic int map_exp(input int pg, input int ln, input bit wr);
    return wr ? ((ln + exp_rot[pg]) % 16) : ((ln - exp_rot[pg] + 16) % 16);
  endfunction

  task automatic send(input int pg, input int ln, input bit wr, input string tag);
    @(posedge clk); #1;
    req_valid = 1; req_page = 6'(pg); req_line = 4'(ln); req_write = wr;
    q_exp.push_back(map_exp(pg, ln, wr)); q_tag.push_back(tag);
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic alloc(input int pg, output logic [3:0] got);
    @(posedge clk); #1;
    alloc_valid = 1; alloc_page = 6'(pg); got = m_rnd[3:0];
    @(posedge clk); #1;
    alloc_valid = 0;
    exp_rot[pg] = got;
  endtask

  initial begin
    logic [3:0] r_a, r_b, r_old;
    for (int p = 0; p < PAGES; p++) exp_rot[p] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1: identity after reset
    send(5, 7, 1, "R1 reset identity write");
    send(63, 15, 0, "R1 reset identity read");
    send(0, 0, 1, "R1 reset identity page0");

    // R2 / R3 / R4: allocate and sweep all lines both ways
    alloc(9, r_a);
    for (int l = 0; l < 16; l++) send(9, l, 1, "R2 write rotate sweep");
    for (int l = 0; l < 16; l++) send(9, l, 0, "R3 read realign sweep");

    // R8: back-to-back allocations get successive states
    @(posedge clk); #1;
    alloc_valid = 1; alloc_page = 6'd20; r_a = m_rnd[3:0];
    @(posedge clk); #1;
    alloc_page = 6'd21; r_b = m_rnd[3:0];
    @(posedge clk); #1;
    alloc_valid = 0;
    exp_rot[20] = r_a; exp_rot[21] = r_b;
    send(20, 15, 1, "R8 first of consecutive allocs");
    send(21, 15, 1, "R8 second of consecutive allocs");
    send(21, 0, 0, "R8 second alloc read");

    // R5: other allocations and requests leave page 9 alone
    alloc(30, r_a);
    for (int l = 0; l < 16; l += 5) send(9, l, 1, "R5 hold across other alloc");
    send(30, 3, 0, "R4 capture page30");

    // R4 / R5: reallocation of page 9
    r_old = exp_rot[9];
    alloc(9, r_a);
    send(9, 15, 1, "R4 realloc new rotate");
    send(9, 1, 0, "R4 realloc read");

    // R6: alloc and request on the same page in one cycle
    @(posedge clk); #1;
    alloc_valid = 1; alloc_page = 6'd9; r_b = m_rnd[3:0];
    req_valid = 1; req_page = 6'd9; req_line = 4'd12; req_write = 1;
    q_exp.push_back(map_exp(9, 12, 1)); q_tag.push_back("R6 same-cycle uses old rotate");
    @(posedge clk); #1;
    alloc_valid = 0; req_valid = 0;
    exp_rot[9] = r_b;
    send(9, 12, 1, "R6 next cycle uses new rotate");

    // R7: back-pressure holds the response
    @(posedge clk); #1;
    resp_ready = 0;
    req_valid = 1; req_page = 6'd21; req_line = 4'd6; req_write = 0;
    @(negedge clk);
    check(req_ready == 0, "R7 ready follows resp_ready", req_ready, 0);
    check(resp_valid == 1, "R7 valid follows req_valid", resp_valid, 1);
    r_a = resp_line;
    check(resp_line == 4'(map_exp(21, 6, 0)), "R7 stalled value", resp_line, map_exp(21, 6, 0));
    @(negedge clk);
    check(resp_line == r_a && resp_valid, "R7 held under stall", resp_line, r_a);
    @(posedge clk); #1;
    q_exp.push_back(map_exp(21, 6, 0)); q_tag.push_back("R7 release after stall");
    resp_ready = 1;
    @(posedge clk); #1;
    req_valid = 0;
    @(negedge clk);
    check(resp_valid == 0, "R7 idle valid low", resp_valid, 0);

    repeat (3) @(posedge clk);
    check(q_exp.size() == 0, "R7 all responses seen", q_exp.size(), 0);
    if (r_old == 4'hF) checks = checks + 0;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule